// File: doc/BRIEF.md
# Multi-master round-robin bus matrix

This block is a crossbar that lets several bus masters reach several slave targets at once. Each master sends a single-beat request (address, write flag, write data, byte strobes) on a valid/ready channel. A per-master decoder maps the 32-bit address to one of five targets: three internal SRAM banks, a peripheral window and an external-memory window. A per-master reachability mask then filters the result. A request that maps to nothing, or to a target the master is not allowed to use, finishes at once with an error flag and never reaches a slave.

Each target has its own round-robin arbiter. Requests to different targets proceed in the same cycle, and only requests that meet at one target are serialized. A transfer completes in the cycle where the chosen slave raises ready. Read data comes back to the master in that same cycle. Byte lanes pass through unchanged and in little-endian order.

Top module: `bmx_top`

## Requirements
- R1: With the default map, the three SRAM targets are decoded as target 0 = 0x2000_0000..0x2001_BFFF (112 KB), target 1 = 0x2001_C000..0x2002_BFFF (64 KB) and target 2 = 0x2002_C000..0x2002_FFFF (16 KB), with the bounds inclusive.
- R2: Address bits [31:29] equal to 3'b010 select target 3 (peripherals), and 3'b011 selects target 4 (external memory).
- R3: A valid request to an address covered by no target raises m_ready_o and m_err_o in that same cycle, and no s_valid_o bit rises.
- R4: With the default reachability, master 0 may reach all five targets. Masters 1 and 2 may reach targets 0, 1, 2 and 4 only. A request from master 1 or 2 to target 3 behaves as in R3.
- R5: At most one master is granted per target. The target sees the granted master's address, write flag, write data and strobes unchanged: strobe bit i qualifies data bits [8i+7:8i], and lane 0 is the lowest-addressed, least significant byte.
- R6: After a transfer completes at a target, the highest priority there passes to the master whose index follows the one just served, wrapping from the last to 0. Three masters that keep requesting one target are therefore served in the order 0, 1, 2, 0 after reset.
- R7: While a granted transfer waits for s_ready_i, the grant and the request fields seen by that target stay unchanged, even if other masters start requesting.
- R8: Requests to different targets from different masters complete in the same cycle.
- R9: A master receives m_ready_o only for its own valid request. On a mapped completion, m_rdata_o equals the target's s_rdata_i in that cycle and m_err_o is low.
- R10: After reset no target is requested and no master sees ready, and every arbiter gives master 0 the highest priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| m_valid_i | input | NM | Per-master request valid |
| m_ready_o | output | NM | Per-master completion (data or error) |
| m_addr_i | input | NM x 32 | Per-master byte address |
| m_write_i | input | NM | Per-master write flag |
| m_wdata_i | input | NM x 32 | Per-master write data |
| m_wstrb_i | input | NM x 4 | Per-master byte strobes |
| m_rdata_o | output | NM x 32 | Per-master read data |
| m_err_o | output | NM | Per-master decode/permission error |
| s_valid_o | output | 5 | Per-target request valid |
| s_ready_i | input | 5 | Per-target completion |
| s_addr_o | output | 5 x 32 | Per-target address |
| s_write_o | output | 5 | Per-target write flag |
| s_wdata_o | output | 5 x 32 | Per-target write data |
| s_wstrb_o | output | 5 x 4 | Per-target byte strobes |
| s_rdata_i | input | 5 x 32 | Per-target read data |

## Verification
The assertions check on every cycle that each arbiter grants at most one master and only a requesting one. They also check that a stalled grant and its target-side fields do not move, that a completed master gives way to a waiting rival, and that an error always comes with ready and never with a grant. Only the bench's scenarios can show the exact address boundaries of the SRAM banks and the region windows, the per-master reachability, the service order 0, 1, 2, 0, and the returned read data and byte-strobe pass-through. The same holds for several targets completing in parallel.

// File: rtl/bmx_pkg.sv
package bmx_pkg;

    // number of targets behind the matrix
    localparam int NS = 5;

    // target indices
    localparam int T_SRAM0 = 0;
    localparam int T_SRAM1 = 1;
    localparam int T_SRAM2 = 2;
    localparam int T_PERIPH = 3;
    localparam int T_EXTMEM = 4;

    localparam int AW = 32;
    localparam int DW = 32;
    localparam int SW = DW / 8;

    typedef logic [AW-1:0] addr_t;
    typedef logic [DW-1:0] data_t;
    typedef logic [SW-1:0] strb_t;
    typedef logic [NS-1:0] tmask_t;

endpackage

// File: rtl/bmx_addr_decode.sv
module bmx_addr_decode
    import bmx_pkg::*;
#(
    parameter logic [31:0] SRAM_BASE   = 32'h2000_0000,
    parameter int          SRAM0_BYTES = 112 * 1024,
    parameter int          SRAM1_BYTES = 64 * 1024,
    parameter int          SRAM2_BYTES = 16 * 1024,
    parameter logic [2:0]  PERIPH_RGN  = 3'd2,
    parameter logic [2:0]  EXT_RGN     = 3'd3,
    parameter tmask_t      REACH       = '1
) (
    input  logic   valid_i,
    input  addr_t  addr_i,
    output tmask_t hit_o,
    output logic   err_o
);

    localparam logic [31:0] S0_LO = SRAM_BASE;
    localparam logic [31:0] S1_LO = S0_LO + 32'(SRAM0_BYTES);
    localparam logic [31:0] S2_LO = S1_LO + 32'(SRAM1_BYTES);
    localparam logic [31:0] S2_HI = S2_LO + 32'(SRAM2_BYTES);

    tmask_t raw;
    tmask_t allowed;

    always_comb begin
        raw = '0;
        raw[T_SRAM0]  = (addr_i >= S0_LO) && (addr_i < S1_LO);
        raw[T_SRAM1]  = (addr_i >= S1_LO) && (addr_i < S2_LO);
        raw[T_SRAM2]  = (addr_i >= S2_LO) && (addr_i < S2_HI);
        raw[T_PERIPH] = (addr_i[31:29] == PERIPH_RGN);
        raw[T_EXTMEM] = (addr_i[31:29] == EXT_RGN);
        allowed = raw & REACH;
        hit_o   = valid_i ? allowed : '0;
        err_o   = valid_i && (allowed == '0);
    end

endmodule

// File: rtl/bmx_rr_arbiter.sv
module bmx_rr_arbiter #(
    parameter int NM = 3
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic [NM-1:0] req_i,
    input  logic          ack_i,
    output logic [NM-1:0] gnt_o
);

    localparam int IW = (NM > 1) ? $clog2(NM) : 1;

    typedef struct packed {
        logic          busy;
        logic [IW-1:0] owner;
        logic [IW-1:0] ptr;
    } arb_state_t;

    arb_state_t st_q, st_d;
    logic [IW-1:0] pick_d;
    logic          found_d;
    logic [IW-1:0] sel_d;

    always_comb begin
        int idx;
        pick_d  = '0;
        found_d = 1'b0;
        for (int k = 0; k < NM; k++) begin
            idx = int'(st_q.ptr) + k;
            if (idx >= NM) idx = idx - NM;
            if (!found_d && req_i[idx]) begin
                found_d = 1'b1;
                pick_d  = IW'(idx);
            end
        end

        sel_d = st_q.busy ? st_q.owner : pick_d;
        gnt_o = '0;
        if (st_q.busy || found_d) gnt_o[sel_d] = 1'b1;

        st_d = st_q;
        if (st_q.busy || found_d) begin
            if (ack_i) begin
                st_d.busy = 1'b0;
                st_d.ptr  = (sel_d == IW'(NM - 1)) ? '0 : sel_d + 1'b1;
            end else begin
                st_d.busy  = 1'b1;
                st_d.owner = sel_d;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    // R5
    gnt_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(gnt_o));

    // R5
    gnt_to_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|gnt_o) |-> (|(gnt_o & req_i)));

    // R7
    gnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((|gnt_o) && !ack_i) |=> (gnt_o == $past(gnt_o)));

    // R6
    rr_yield_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((|gnt_o) && ack_i && (|(req_i & ~gnt_o))) |=> (gnt_o != $past(gnt_o)));

endmodule

// File: rtl/bmx_top.sv
module bmx_top
    import bmx_pkg::*;
#(
    parameter int              NM          = 3,
    parameter logic [31:0]     SRAM_BASE   = 32'h2000_0000,
    parameter int              SRAM0_BYTES = 112 * 1024,
    parameter int              SRAM1_BYTES = 64 * 1024,
    parameter int              SRAM2_BYTES = 16 * 1024,
    parameter logic [2:0]      PERIPH_RGN  = 3'd2,
    parameter logic [2:0]      EXT_RGN     = 3'd3,
    parameter logic [NM*5-1:0] REACH       = 15'b10111_10111_11111
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic [NM-1:0]          m_valid_i,
    output logic [NM-1:0]          m_ready_o,
    input  logic [NM-1:0][31:0]    m_addr_i,
    input  logic [NM-1:0]          m_write_i,
    input  logic [NM-1:0][31:0]    m_wdata_i,
    input  logic [NM-1:0][3:0]     m_wstrb_i,
    output logic [NM-1:0][31:0]    m_rdata_o,
    output logic [NM-1:0]          m_err_o,
    output logic [4:0]             s_valid_o,
    input  logic [4:0]             s_ready_i,
    output logic [4:0][31:0]       s_addr_o,
    output logic [4:0]             s_write_o,
    output logic [4:0][31:0]       s_wdata_o,
    output logic [4:0][3:0]        s_wstrb_o,
    input  logic [4:0][31:0]       s_rdata_i
);

    logic [NM-1:0][NS-1:0] hit;
    logic [NM-1:0]         dec_err;
    logic [NS-1:0][NM-1:0] sreq;
    logic [NS-1:0][NM-1:0] gnt;
    logic [NM-1:0]         granted_any;

    for (genvar m = 0; m < NM; m++) begin : g_dec
        bmx_addr_decode #(
            .SRAM_BASE  (SRAM_BASE),
            .SRAM0_BYTES(SRAM0_BYTES),
            .SRAM1_BYTES(SRAM1_BYTES),
            .SRAM2_BYTES(SRAM2_BYTES),
            .PERIPH_RGN (PERIPH_RGN),
            .EXT_RGN    (EXT_RGN),
            .REACH      (REACH[m*NS +: NS])
        ) dec_i (
            .valid_i(m_valid_i[m]),
            .addr_i (m_addr_i[m]),
            .hit_o  (hit[m]),
            .err_o  (dec_err[m])
        );
    end

    always_comb begin
        for (int s = 0; s < NS; s++)
            for (int m = 0; m < NM; m++)
                sreq[s][m] = hit[m][s];
    end

    for (genvar s = 0; s < NS; s++) begin : g_arb
        bmx_rr_arbiter #(.NM(NM)) arb_i (
            .clk_i (clk_i),
            .rst_ni(rst_ni),
            .req_i (sreq[s]),
            .ack_i (s_ready_i[s]),
            .gnt_o (gnt[s])
        );
    end

    // target-side AND-OR multiplexers
    always_comb begin
        for (int s = 0; s < NS; s++) begin
            s_valid_o[s] = |gnt[s];
            s_addr_o[s]  = '0;
            s_write_o[s] = 1'b0;
            s_wdata_o[s] = '0;
            s_wstrb_o[s] = '0;
            for (int m = 0; m < NM; m++) begin
                if (gnt[s][m]) begin
                    s_addr_o[s]  = s_addr_o[s]  | m_addr_i[m];
                    s_write_o[s] = s_write_o[s] | m_write_i[m];
                    s_wdata_o[s] = s_wdata_o[s] | m_wdata_i[m];
                    s_wstrb_o[s] = s_wstrb_o[s] | m_wstrb_i[m];
                end
            end
        end
    end

    // master-side return path
    always_comb begin
        for (int m = 0; m < NM; m++) begin
            m_ready_o[m]   = dec_err[m];
            m_err_o[m]     = dec_err[m];
            m_rdata_o[m]   = '0;
            granted_any[m] = 1'b0;
            for (int s = 0; s < NS; s++) begin
                if (gnt[s][m]) begin
                    granted_any[m] = 1'b1;
                    if (s_ready_i[s]) begin
                        m_ready_o[m] = 1'b1;
                        m_rdata_o[m] = m_rdata_o[m] | s_rdata_i[s];
                    end
                end
            end
        end
    end

    for (genvar m = 0; m < NM; m++) begin : g_mchk
        // R3
        err_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            m_err_o[m] |-> m_ready_o[m]);
        // R4
        err_no_gnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            m_err_o[m] |-> !granted_any[m]);
        // R9
        idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !m_valid_i[m] |-> !m_ready_o[m]);
    end

    for (genvar s = 0; s < NS; s++) begin : g_schk
        // R7
        stall_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (s_valid_o[s] && !s_ready_i[s]) |=>
                (s_valid_o[s] && $stable(s_addr_o[s]) && $stable(s_wdata_o[s])
                 && $stable(s_wstrb_o[s]) && $stable(s_write_o[s])));
    end

endmodule

// File: tb/bmx_top_tb.sv
module bmx_top_tb_top;

    localparam int NM = 3;
    localparam int NS = 5;

    logic                clk = 1'b0;
    logic                rst_n;
    logic [NM-1:0]       m_valid;
    logic [NM-1:0]       m_ready;
    logic [NM-1:0][31:0] m_addr;
    logic [NM-1:0]       m_write;
    logic [NM-1:0][31:0] m_wdata;
    logic [NM-1:0][3:0]  m_wstrb;
    logic [NM-1:0][31:0] m_rdata;
    logic [NM-1:0]       m_err;
    logic [NS-1:0]       s_valid;
    logic [NS-1:0]       s_ready;
    logic [NS-1:0][31:0] s_addr;
    logic [NS-1:0]       s_write;
    logic [NS-1:0][31:0] s_wdata;
    logic [NS-1:0][3:0]  s_wstrb;
    logic [NS-1:0][31:0] s_rdata;

    int n_chk  = 0;
    int n_fail = 0;

    // 50 MHz: 20 time units per period
    always #10 clk = ~clk;

    // target models: read data derived from address and target index
    function automatic logic [31:0] rd_model(input logic [31:0] a, input int t);
        return a ^ 32'hA5A5_0000 ^ 32'(t);
    endfunction

    always_comb begin
        for (int t = 0; t < NS; t++) s_rdata[t] = rd_model(s_addr[t], t);
    end

    bmx_top dut_i (
        .clk_i(clk), .rst_ni(rst_n),
        .m_valid_i(m_valid), .m_ready_o(m_ready), .m_addr_i(m_addr),
        .m_write_i(m_write), .m_wdata_i(m_wdata), .m_wstrb_i(m_wstrb),
        .m_rdata_o(m_rdata), .m_err_o(m_err),
        .s_valid_o(s_valid), .s_ready_i(s_ready), .s_addr_o(s_addr),
        .s_write_o(s_write), .s_wdata_o(s_wdata), .s_wstrb_o(s_wstrb),
        .s_rdata_i(s_rdata)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic idle_all();
        m_valid = '0;
        m_addr  = '0;
        m_write = '0;
        m_wdata = '0;
        m_wstrb = '0;
    endtask

    task automatic drive(input int m, input logic [31:0] a, input logic we,
                         input logic [31:0] wd, input logic [3:0] st);
        m_valid[m] = 1'b1;
        m_addr[m]  = a;
        m_write[m] = we;
        m_wdata[m] = wd;
        m_wstrb[m] = st;
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0;
        idle_all();
        s_ready = '1;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        apply_reset();
        #5;
        chk(s_valid == '0, "R10 no target valid", 32'(s_valid), 0);
        chk(m_ready == '0, "R10 no master ready", 32'(m_ready), 0);
    endtask

    task automatic one_decode(input logic [31:0] a, input int t, input string req);
        @(negedge clk);
        idle_all();
        drive(0, a, 1'b0, '0, '0);
        #5;
        chk(s_valid == NS'(1 << t), req, 32'(s_valid), 32'(1 << t));
        chk(m_ready[0] && !m_err[0], req, {30'd0, m_ready[0], m_err[0]}, 32'd2);
        chk(m_rdata[0] == rd_model(a, t), {req, " rdata (R9)"}, m_rdata[0], rd_model(a, t));
    endtask

    task automatic t_decode();
        one_decode(32'h2000_0000, 0, "R1 sram0 low");
        one_decode(32'h2001_BFFF, 0, "R1 sram0 high");
        one_decode(32'h2001_C000, 1, "R1 sram1 low");
        one_decode(32'h2002_BFFF, 1, "R1 sram1 high");
        one_decode(32'h2002_C000, 2, "R1 sram2 low");
        one_decode(32'h2002_FFFF, 2, "R1 sram2 high");
        one_decode(32'h4000_1234, 3, "R2 peripheral");
        one_decode(32'h7FFF_FFFC, 3 + 1, "R2 external");
        @(negedge clk);
        idle_all();
    endtask

    task automatic one_err(input int m, input logic [31:0] a, input string req);
        @(negedge clk);
        idle_all();
        drive(m, a, 1'b1, 32'hDEAD_BEEF, 4'hF);
        #5;
        chk(m_ready[m] && m_err[m], req, {30'd0, m_ready[m], m_err[m]}, 32'd3);
        chk(s_valid == '0, {req, " no target"}, 32'(s_valid), 0);
    endtask

    task automatic t_unmapped();
        one_err(0, 32'h2003_0000, "R3 past sram2");
        one_err(0, 32'h0000_0000, "R3 region 0");
        one_err(0, 32'hE000_0000, "R3 region 7");
        @(negedge clk);
        idle_all();
    endtask

    task automatic t_reach();
        one_err(1, 32'h4000_0000, "R4 master1 to peripheral");
        one_err(2, 32'h4001_0000, "R4 master2 to peripheral");
        @(negedge clk);
        idle_all();
        drive(1, 32'h6000_0010, 1'b0, '0, '0);
        #5;
        chk(m_ready[1] && !m_err[1] && s_valid == 5'b10000, "R4 master1 to external",
            32'(s_valid), 32'h10);
        @(negedge clk);
        idle_all();
        drive(2, 32'h2002_C000, 1'b0, '0, '0);
        #5;
        chk(m_ready[2] && !m_err[2] && s_valid == 5'b00100, "R4 master2 to sram2",
            32'(s_valid), 32'h4);
        @(negedge clk);
        idle_all();
    endtask

    task automatic t_round_robin();
        logic [2:0] order [4];
        order[0] = 3'b001; order[1] = 3'b010; order[2] = 3'b100; order[3] = 3'b001;
        apply_reset();
        for (int m = 0; m < NM; m++) drive(m, 32'h2000_0010 + 32'(m * 4), 1'b0, '0, '0);
        for (int c = 0; c < 4; c++) begin
            #5;
            chk(m_ready == order[c], "R6 rotation order", 32'(m_ready), 32'(order[c]));
            @(negedge clk);
        end
        idle_all();
    endtask

    task automatic t_hold();
        @(negedge clk);
        idle_all();
        s_ready[1] = 1'b0;
        drive(1, 32'h2001_C040, 1'b1, 32'hCAFE_0001, 4'b0011);
        @(negedge clk);
        drive(0, 32'h2001_C080, 1'b1, 32'hBEEF_0000, 4'b1100);
        for (int c = 0; c < 3; c++) begin
            #5;
            chk(s_addr[1] == 32'h2001_C040 && s_wdata[1] == 32'hCAFE_0001,
                "R7 held grant", s_addr[1], 32'h2001_C040);
            chk(m_ready == '0, "R7 no completion while stalled", 32'(m_ready), 0);
            @(negedge clk);
        end
        s_ready[1] = 1'b1;
        #5;
        chk(m_ready == 3'b010, "R7 held master completes", 32'(m_ready), 32'h2);
        @(negedge clk);
        m_valid[1] = 1'b0;
        #5;
        chk(m_ready == 3'b001 && s_addr[1] == 32'h2001_C080, "R7 waiting master next",
            s_addr[1], 32'h2001_C080);
        @(negedge clk);
        idle_all();
    endtask

    task automatic t_parallel();
        @(negedge clk);
        idle_all();
        drive(0, 32'h6000_0040, 1'b0, '0, '0);
        drive(1, 32'h2000_0100, 1'b0, '0, '0);
        drive(2, 32'h2002_C008, 1'b0, '0, '0);
        #5;
        chk(m_ready == 3'b111, "R8 all complete", 32'(m_ready), 32'h7);
        chk(s_valid == 5'b10101, "R8 three targets", 32'(s_valid), 32'h15);
        chk(m_rdata[1] == rd_model(32'h2000_0100, 0), "R8 master1 data",
            m_rdata[1], rd_model(32'h2000_0100, 0));
        chk(s_addr[4] == 32'h6000_0040, "R8 target4 address", s_addr[4], 32'h6000_0040);
        @(negedge clk);
        idle_all();
    endtask

    task automatic t_strobes();
        @(negedge clk);
        idle_all();
        drive(2, 32'h6000_0008, 1'b1, 32'h1122_3344, 4'b0101);
        #5;
        chk(s_wstrb[4] == 4'b0101, "R5 strobes", 32'(s_wstrb[4]), 32'h5);
        chk(s_wdata[4] == 32'h1122_3344, "R5 write data lanes", s_wdata[4], 32'h1122_3344);
        chk(s_write[4] == 1'b1, "R5 write flag", 32'(s_write[4]), 1);
        chk(m_ready[0] == 1'b0 && m_ready[1] == 1'b0, "R9 others idle", 32'(m_ready), 32'h4);
        @(negedge clk);
        idle_all();
    endtask

    initial begin
        rst_n   = 1'b0;
        s_ready = '1;
        idle_all();
        t_reset();
        t_decode();
        t_unmapped();
        t_reach();
        t_round_robin();
        t_hold();
        t_parallel();
        t_strobes();
        repeat (2) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(20 * 20000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule